// File: doc/BRIEF.md
# Serial Interface Baud Clock Generator

This block makes the bit-clock enables for the transmit and receive halves of a serial communication port. It runs from the system clock and has one 24-bit control register. For each direction the register picks an internal divided clock or an external clock taken from a shared serial clock pin. It also sets a 12-bit divide value, an optional divide-by-8 prescaler and the divide ratio for the pin output. The block returns one-cycle enable pulses, `tx_en` and `rx_en`, which the shifters elsewhere in the port use. It also controls the pin direction through an output enable.

The internal chain has three stages. A prescaler divides by 1 or 8. A reloading 12-bit counter then gives one tick every D+1 prescaled clocks. A final stage halves that rate to give the interface clock. When both directions use the internal clock, a pin-driver state machine drives the serial clock pin. The machine has three states, `PIN_IN`, `PIN_LO` and `PIN_HI`. It moves `PIN_IN→PIN_LO` when the pin becomes an output and toggles `PIN_LO↔PIN_HI` after a mode-dependent count of divider ticks. It moves from any state to `PIN_IN` when either direction selects the external clock. A register write sends the machine to `PIN_LO`, or to `PIN_IN` if the pin is an input. When the pin is an input, its rising edges pass through a two-stage synchronizer and become enables for each direction that selects the external clock. The `sync_sel` input tells the block whether the port runs synchronously. `sync_ok` reports whether the source selection permits that.

Top module: `baud_clk_gen`

## Requirements
- R1: After reset the register reads 0. `pin_oe` is 1 and `pin_out` is 0.
- R2: A write stores bits 15:0 of `wr_data`. Bits 23:16 always read 0, whatever was written to them.
- R3: Bit 15 selects the transmit source and bit 14 the receive source, with 0 for internal and 1 for external. A direction with the external source gives exactly one enable pulse for each rising edge of `pin_in`.
- R4: `pin_oe` is 1 only when bits 15 and 14 are both 0. While `pin_oe` is 0, `pin_out` stays 0.
- R5: `sync_ok` is 1 exactly when bits 15 and 14 are equal.
- R6: An internal-source enable repeats every 2·(D+1)·P cycles. D is bits 11:0. P is 1 when bit 13 is 0 and 8 when bit 13 is 1.
- R7: With the pin as an output and `sync_sel`=1, the pin clock period is 4·(D+1)·P cycles, whatever the value of bit 12.
- R8: With the pin as an output and `sync_sel`=0, the pin clock period is 32·(D+1)·P cycles when bit 12 is 0 and 2·(D+1)·P cycles when bit 12 is 1.
- R9: Every register write restarts the internal chain. The rising edge that accepts the write is edge 0. The first internal enable after the write is set by edge 2·(D+1)·P, so there is no partial period.
- R10: No enable pulse is ever longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 24 | Register write value |
| rd_data | output | 24 | Register read value |
| sync_sel | input | 1 | 1 when the port runs in synchronous mode |
| pin_in | input | 1 | Serial clock pin, input side |
| pin_out | output | 1 | Serial clock pin, output side |
| pin_oe | output | 1 | Serial clock pin output enable |
| tx_en | output | 1 | Transmit bit-clock enable pulse |
| rx_en | output | 1 | Receive bit-clock enable pulse |
| sync_ok | output | 1 | Source selection permits synchronous mode |

## Verification
The bench measures enable intervals at the smallest divide value, a mid value with the prescaler on and the largest 12-bit value. An off-by-one reload or a prescaler that ignores its bit would show up there as a wrong period. It measures the pin period in all three output-divider cases, so a design that used bit 12 in synchronous mode, or swapped the 1x and 16x ratios, would give a pin period 2 or 16 times off. It writes during a running period and times the first enable. A design that failed to restart its counters would give a short first pulse. It also sets each source to external separately, checking that pulses follow pin edges only in that direction, that the pin direction changes and that the reserved bits stay zero.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int REG_W      = 24;
    localparam int DIV_W      = 12;
    localparam int PSC_RATIO  = 8;
    localparam int SLOW_RATIO = 16;
    localparam int CFG_W      = DIV_W + 4;

    typedef struct packed {
        logic             tx_ext;
        logic             rx_ext;
        logic             psc_on;
        logic             out_fast;
        logic [DIV_W-1:0] div_val;
    } baud_cfg_t;

    typedef enum logic [1:0] {
        PIN_IN = 2'd0,
        PIN_LO = 2'd1,
        PIN_HI = 2'd2
    } pin_state_t;
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output baud_cfg_t        cfg,
    output logic             restart
);
    localparam int PAD_W = REG_W - CFG_W;

    baud_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= baud_cfg_t'(wr_data[CFG_W-1:0]);
        end
    end

    assign cfg     = cfg_q;
    assign rd_data = {{PAD_W{1'b0}}, cfg_q};
    assign restart = wr_en;
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int DIV_W     = 12,
    parameter int PSC_RATIO = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             psc_on,
    input  logic [DIV_W-1:0] div_val,
    output logic             div_tick,
    output logic             sci_tick
);
    localparam int PSC_W = (PSC_RATIO > 1) ? $clog2(PSC_RATIO) : 1;
    localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(PSC_RATIO - 1);

    logic [PSC_W-1:0] psc_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             half;
    logic             psc_tick;

    assign psc_tick = psc_on ? (psc_cnt == PSC_LAST) : 1'b1;
    assign div_tick = psc_tick && (div_cnt == div_val);
    assign sci_tick = div_tick && half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_cnt <= '0;
            div_cnt <= '0;
            half    <= 1'b0;
        end else if (restart) begin
            psc_cnt <= '0;
            div_cnt <= '0;
            half    <= 1'b0;
        end else begin
            if (psc_on) begin
                psc_cnt <= (psc_cnt == PSC_LAST) ? '0 : psc_cnt + 1'b1;
            end else begin
                psc_cnt <= '0;
            end
            if (psc_tick) begin
                div_cnt <= div_tick ? '0 : div_cnt + 1'b1;
            end
            if (div_tick) begin
                half <= ~half;
            end
        end
    end
endmodule

// File: rtl/baud_pin_sync.sv
module baud_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_rise
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], pin_in};
        end
    end

    assign pin_rise = shreg[STAGES-1] && !shreg[STAGES];
endmodule

// File: rtl/baud_pin_fsm.sv
module baud_pin_fsm
    import baud_pkg::*;
#(
    parameter int SLOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic drive,
    input  logic sync_sel,
    input  logic out_fast,
    input  logic div_tick,
    output logic pin_out
);
    localparam int CNT_W = $clog2(SLOW);
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(SLOW - 1);
    localparam logic [CNT_W-1:0] LIM_SYNC = CNT_W'(1);
    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(0);

    pin_state_t       state, state_nx;
    logic [CNT_W-1:0] tog_cnt;
    logic [CNT_W-1:0] lim;
    logic             flip;

    always_comb begin
        if (sync_sel)      lim = LIM_SYNC;
        else if (out_fast) lim = LIM_FAST;
        else               lim = LIM_SLOW;
    end

    assign flip = div_tick && (tog_cnt >= lim);

    always_comb begin
        state_nx = state;
        if (restart) begin
            state_nx = drive ? PIN_LO : PIN_IN;
        end else begin
            unique case (state)
                PIN_IN: if (drive) state_nx = PIN_LO;
                PIN_LO: begin
                    if (!drive)    state_nx = PIN_IN;
                    else if (flip) state_nx = PIN_HI;
                end
                PIN_HI: begin
                    if (!drive)    state_nx = PIN_IN;
                    else if (flip) state_nx = PIN_LO;
                end
                default: state_nx = PIN_IN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= PIN_LO;
            tog_cnt <= '0;
        end else begin
            state <= state_nx;
            if (restart || state == PIN_IN || !drive) begin
                tog_cnt <= '0;
            end else if (div_tick) begin
                tog_cnt <= flip ? '0 : tog_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            PIN_HI:  pin_out = 1'b1;
            default: pin_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             sync_sel,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             tx_en,
    output logic             rx_en,
    output logic             sync_ok
);
    baud_cfg_t cfg;
    logic      restart;
    logic      div_tick;
    logic      sci_tick;
    logic      pin_rise;
    logic      drive;

    baud_cfg_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg     (cfg),
        .restart (restart)
    );

    baud_divider #(.DIV_W(DIV_W), .PSC_RATIO(PSC_RATIO)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .psc_on   (cfg.psc_on),
        .div_val  (cfg.div_val),
        .div_tick (div_tick),
        .sci_tick (sci_tick)
    );

    baud_pin_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_rise (pin_rise)
    );

    assign drive = !cfg.tx_ext && !cfg.rx_ext;

    baud_pin_fsm #(.SLOW(SLOW_RATIO)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .drive    (drive),
        .sync_sel (sync_sel),
        .out_fast (cfg.out_fast),
        .div_tick (div_tick),
        .pin_out  (pin_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else begin
            tx_en <= cfg.tx_ext ? pin_rise : sci_tick;
            rx_en <= cfg.rx_ext ? pin_rise : sci_tick;
        end
    end

    assign pin_oe  = drive;
    assign sync_ok = (cfg.tx_ext == cfg.rx_ext);
endmodule

// File: rtl/baud_clk_gen_chk.sv
module baud_clk_gen_chk
    import baud_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             sync_sel,
    input logic             pin_in,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             tx_en,
    input logic             rx_en,
    input logic             sync_ok
);
    a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == {{(REG_W-16){1'b0}}, $past(wr_data[15:0])});

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:16] == '0);

    a_r4_oe_from_sources: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe == (rd_data[15:14] == 2'b00));

    a_r4_quiet_when_input: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |=> !pin_out);

    a_r5_sync_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok == (rd_data[15] == rd_data[14]));

    a_r10_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |=> !tx_en);

    a_r10_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |=> !rx_en);
endmodule

bind baud_clk_gen baud_clk_gen_chk i_chk (.*);

// File: tb/test_baud_clk_gen.sv
module test_baud_clk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_data = '0;
    logic [23:0] rd_data;
    logic        sync_sel = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, tx_en, rx_en, sync_ok;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    int  exp_q[$];
    bit  mon_arm = 1'b0;
    bit  have_ref = 1'b0;
    int  gap = 0;

    always #5 clk = ~clk;

    baud_clk_gen i_baud_clk_gen (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measures tx_en intervals and pops expected items.
    always @(negedge clk) begin
        if (!mon_arm) begin
            have_ref = 1'b0;
            gap = 0;
        end else begin
            gap++;
            if (tx_en) begin
                if (have_ref && exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    chk(gap == e, "R6 tx interval", gap, e);
                end
                have_ref = 1'b1;
                gap = 0;
            end
        end
    end

    task automatic write_reg(input logic [23:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: configure, push expected intervals, wait for the monitor.
    task automatic run_intervals(input logic [23:0] v, input int n, input int exp);
        write_reg(v);
        for (int i = 0; i < n; i++) exp_q.push_back(exp);
        mon_arm = 1'b1;
        for (int t = 0; t < (n + 2) * exp + 50 && exp_q.size() > 0; t++) @(negedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        exp_q.delete();
        mon_arm = 1'b0;
        @(negedge clk);
    endtask

    task automatic pin_period(input string req, input int exp);
        int t0, t1, lim;
        lim = 4 * exp + 100;
        t0 = 0;
        for (int t = 0; t < lim; t++) begin
            @(negedge clk);
            if (pin_out) begin t0 = t; break; end
        end
        for (int t = t0; t < lim; t++) begin
            @(negedge clk);
            if (!pin_out) break;
        end
        t1 = 0;
        for (int t = 0; t < lim; t++) begin
            @(negedge clk);
            if (pin_out) begin t1 = t + 1; break; end
        end
        // measure a full period from this rising edge to the next one
        t0 = 0;
        for (int t = 0; t < lim; t++) begin
            @(negedge clk);
            t0++;
            if (!pin_out) break;
        end
        for (int t = 0; t < lim; t++) begin
            @(negedge clk);
            t0++;
            if (pin_out) break;
        end
        chk(t0 == exp && t1 > 0, req, t0, exp);
    endtask

    task automatic ext_test(input logic [23:0] v, input bit tx_side);
        int ext_cnt, int_cnt;
        write_reg(v);
        ext_cnt = 0;
        int_cnt = 0;
        for (int k = 0; k < 5; k++) begin
            for (int h = 0; h < 10; h++) begin
                @(negedge clk);
                pin_in = (h < 5);
                if (tx_side ? tx_en : rx_en) ext_cnt++;
                if (tx_side ? rx_en : tx_en) int_cnt++;
                if (pin_out) int_cnt = -1000;
            end
        end
        for (int h = 0; h < 10; h++) begin
            @(negedge clk);
            if (tx_side ? tx_en : rx_en) ext_cnt++;
        end
        chk(ext_cnt == 5, tx_side ? "R3 tx follows pin edges" : "R3 rx follows pin edges", ext_cnt, 5);
        chk(int_cnt > 0, "R3 other side internal, R4 pin quiet", int_cnt, 1);
        chk(pin_oe == 1'b0, "R4 pin input", pin_oe, 0);
        chk(sync_ok == 1'b0, "R5 mixed sources", sync_ok, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 24'h0, "R1 register zero", rd_data, 0);
        chk(pin_oe == 1'b1, "R1 pin driven", pin_oe, 1);
        chk(pin_out == 1'b0, "R1 pin low", pin_out, 0);
        chk(sync_ok == 1'b1, "R5 both internal", sync_ok, 1);

        // R2 reserved bits ignored
        write_reg(24'hFF_2A5C);
        chk(rd_data == 24'h00_2A5C, "R2 reserved read zero", rd_data, 24'h2A5C);

        // R6 intervals
        run_intervals(24'h000000, 4, 2);
        run_intervals(24'h000003, 4, 8);
        run_intervals(24'h002002, 3, 48);
        run_intervals(24'h000FFF, 2, 8192);

        // R9 restart latency: write mid-period, count edges to first enable
        write_reg(24'h000003);
        repeat (5) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 24'h000003;
        @(negedge clk);
        wr_en = 1'b0;
        k = 1;
        while (!tx_en && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk(k == 9, "R9 restart D=3 P=1", k, 9);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 24'h002001;
        @(negedge clk);
        wr_en = 1'b0;
        k = 1;
        while (!tx_en && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk(k == 33, "R9 restart D=1 P=8", k, 33);

        // R7 synchronous pin output
        sync_sel = 1'b1;
        write_reg(24'h000001);
        pin_period("R7 sync pin period bit12=0", 8);
        write_reg(24'h001001);
        pin_period("R7 sync pin period bit12=1", 8);

        // R8 asynchronous pin output
        sync_sel = 1'b0;
        write_reg(24'h001001);
        pin_period("R8 async fast pin period", 4);
        write_reg(24'h000001);
        pin_period("R8 async slow pin period", 64);

        // R3/R4/R5 external sources
        ext_test(24'h008001, 1'b1);
        ext_test(24'h004001, 1'b0);

        write_reg(24'h00C001);
        chk(pin_oe == 1'b0 && sync_ok == 1'b1, "R4 R5 both external", {pin_oe, sync_ok}, 1);
        write_reg(24'h000001);
        chk(pin_oe == 1'b1, "R4 pin back to output", pin_oe, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule